// File: doc/BRIEF.md
# Bus Prescaler and Timer Clock-Enable Tree

This block turns one fast system clock into a family of single-cycle clock-enable strobes. The logic of every domain keeps running on the system clock and advances only in cycles where its strobe is high. A main-bus prescaler sets the base rate. Two peripheral-bus prescalers, a core tick timer and an ADC divider are chained behind it, so every derived strobe falls in a cycle where the main-bus strobe is also high. Each peripheral bus also drives a timer strobe. That strobe runs at the bus rate when the bus is undivided and at twice the bus rate otherwise.

Each bus has a bank of per-peripheral gates. A peripheral strobe pulses only when its gate bit is set. After reset, every gate is closed except the one for the memory interface on the main bus. Prescaler settings and gate bits may change at any time. A new prescaler value is taken only when the current divided period ends, so a strobe period is never cut short. A gate bit is sampled on each of its bus's strobes.

Top module: `clk_strobe_tree`

## Requirements
- R1: `hb_ce` pulses once every Dh system cycles. `hb_sel` encodes Dh: any value with bit 3 clear gives 1. Values 8 through 15 give 2, 4, 8, 16, 64, 128, 256 and 512 in that order, so a divide of 32 is never produced.
- R2: `tick_ce` pulses once for every 8 `hb_ce` pulses (parameter TICK_DIV), and its period is 8·Dh cycles.
- R3: `p1_ce` and `p2_ce` pulse once every Dp `hb_ce` pulses. Each 3-bit select (`p1_sel`, `p2_sel`) encodes its own Dp: bit 2 clear gives 1, and 4, 5, 6, 7 give 2, 4, 8, 16. Every bus pulse coincides with an `hb_ce` pulse.
- R4: When its bus has Dp = 1, `t1_ce` (or `t2_ce`) is the same as the bus strobe. Otherwise it pulses every Dh·Dp/2 cycles, which is twice the bus rate. Every bus pulse is also a timer pulse.
- R5: `adc_ce` pulses once every Da `p2_ce` pulses. `adc_sel` encodes Da as 0→2, 1→4, 2→6, 3→8.
- R6: Bit i of `hb_en`, `p1_en` or `p2_en` pulses only in the cycle of its bus strobe, and only if its gate is open. The gate input is sampled at every bus strobe and controls the next bus strobe after that, not the one in the cycle where it is sampled.
- R7: After reset, every gate is closed except main-bus gate MEM_IDX (default 0). That bit therefore pulses on the first `hb_ce` after reset even when `hb_gate` is all zero.
- R8: A change of `hb_sel` takes effect only at the end of the running period. Every interval between `hb_ce` pulses therefore equals the old or the new Dh, and never anything shorter.
- R9: While `rst` is high, all strobe outputs are low.
- R10: Every output strobe is registered. Each derived strobe is high only in a cycle where its source strobe is high (`hb_ce` for the buses, tick and timers; `p2_ce` for the ADC).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_sel | input | 4 | Main-bus prescaler select |
| p1_sel | input | 3 | Peripheral bus 1 prescaler select |
| p2_sel | input | 3 | Peripheral bus 2 prescaler select |
| adc_sel | input | 2 | ADC divider select |
| hb_gate | input | N_HB | Main-bus peripheral gates |
| p1_gate | input | N_P1 | Bus 1 peripheral gates |
| p2_gate | input | N_P2 | Bus 2 peripheral gates |
| hb_ce | output | 1 | Main-bus and free-running core strobe |
| tick_ce | output | 1 | Core tick timer strobe |
| p1_ce | output | 1 | Peripheral bus 1 strobe |
| p2_ce | output | 1 | Peripheral bus 2 strobe |
| t1_ce | output | 1 | Bus 1 timer strobe |
| t2_ce | output | 1 | Bus 2 timer strobe |
| adc_ce | output | 1 | ADC strobe |
| hb_en | output | N_HB | Gated main-bus peripheral strobes |
| p1_en | output | N_P1 | Gated bus 1 peripheral strobes |
| p2_en | output | N_P2 | Gated bus 2 peripheral strobes |

## Verification
The bench measures the interval between consecutive pulses of every strobe once a setting has settled. It compares each interval with a period computed from the select encodings. A decode that skipped or duplicated the missing divide of 32, or a timer rule that doubled a divide-by-1 bus, would show up as a wrong interval.

The bench also switches between the slowest and fastest main-bus settings. During such a switch it accepts only the old or the new period, which catches a divider that loads a new value in the middle of a period and emits a short pulse.

Directed runs cover the following:
- the memory gate firing once after reset with all gate inputs low;
- the one-strobe lag when a gate is opened or closed, which a design that bypassed the sampled gate would get wrong.

// File: rtl/ckt_pkg.sv
package ckt_pkg;

  localparam int HB_SEL_W  = 4;
  localparam int PB_SEL_W  = 3;
  localparam int ADC_SEL_W = 2;
  localparam int HB_CW     = 9;  // holds divide-1 up to 511
  localparam int PB_CW     = 4;  // holds divide-1 up to 15
  localparam int ADC_CW    = 3;  // holds divide-1 up to 7

  // main bus: top bit clear -> /1, else powers of two skipping 32
  function automatic logic [HB_CW-1:0] hb_div_m1(input logic [HB_SEL_W-1:0] s);
    int sh;
    logic [HB_CW:0] p;
    if (!s[HB_SEL_W-1]) return '0;
    sh = s[2] ? int'(s[1:0]) + 6 : int'(s[1:0]) + 1;
    p  = (HB_CW+1)'(1) << sh;
    return HB_CW'(p - 1'b1);
  endfunction

  // peripheral bus: top bit clear -> /1, else 2,4,8,16
  function automatic logic [PB_CW-1:0] pb_div_m1(input logic [PB_SEL_W-1:0] s);
    logic [PB_CW:0] p;
    if (!s[PB_SEL_W-1]) return '0;
    p = (PB_CW+1)'(1) << (int'(s[1:0]) + 1);
    return PB_CW'(p - 1'b1);
  endfunction

  // ADC: 2*(s+1), minus one
  function automatic logic [ADC_CW-1:0] adc_div_m1(input logic [ADC_SEL_W-1:0] s);
    return ADC_CW'({s, 1'b1});
  endfunction

endpackage

// File: rtl/ckt_div.sv
module ckt_div #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_tick,
  input  logic [CW-1:0] div_m1,
  output logic          tick
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cur;
  logic          at_end;

  assign at_end = (cnt == cur);
  assign tick   = in_tick & at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      cur <= div_m1;
    end else if (in_tick) begin
      if (at_end) begin
        cnt <= '0;
        cur <= div_m1;  // new setting only at a period boundary
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_DIV_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt <= cur)
    else $error("divider count passed its limit"); // R8

endmodule

// File: rtl/ckt_bus_pre.sv
module ckt_bus_pre
  import ckt_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_tick,
  input  logic [PB_SEL_W-1:0] sel,
  output logic                bus_tick,
  output logic                tim_tick
);

  logic [PB_CW-1:0] cnt;
  logic [PB_CW-1:0] cur;
  logic             at_end;
  logic             at_mid;

  assign at_end   = (cnt == cur);
  assign at_mid   = (cnt == (cur >> 1));
  assign bus_tick = in_tick & at_end;
  // undivided bus: mid and end coincide, so the timer runs at bus rate
  assign tim_tick = in_tick & (at_end | at_mid);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      cur <= pb_div_m1(sel);
    end else if (in_tick) begin
      if (at_end) begin
        cnt <= '0;
        cur <= pb_div_m1(sel);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_TIM_HAS_BUS: assert property (@(posedge clk) disable iff (rst) bus_tick |-> tim_tick)
    else $error("bus pulse without timer pulse"); // R4
  AST_BUS_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt <= cur)
    else $error("bus count passed its limit"); // R8

endmodule

// File: rtl/ckt_gate_bank.sv
module ckt_gate_bank #(
  parameter int           N       = 4,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [N-1:0] gate_in,
  output logic [N-1:0] en
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q_b;
    logic en_b;

    always_ff @(posedge clk) begin
      if (rst) begin
        q_b  <= RST_VAL[i];
        en_b <= 1'b0;
      end else begin
        en_b <= tick & q_b;
        if (tick) q_b <= gate_in[i];
      end
    end

    assign en[i] = en_b;

    AST_GATE_QUIET: assert property (@(posedge clk) disable iff (rst) !tick |=> !en_b)
      else $error("gated strobe without bus strobe"); // R6
    AST_GATE_RST_VAL: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> q_b == RST_VAL[i])
      else $error("gate reset value wrong"); // R7
  end

endmodule

// File: rtl/clk_strobe_tree.sv
module clk_strobe_tree
  import ckt_pkg::*;
#(
  parameter int N_HB     = 4,
  parameter int N_P1     = 8,
  parameter int N_P2     = 6,
  parameter int MEM_IDX  = 0,
  parameter int TICK_DIV = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [HB_SEL_W-1:0]  hb_sel,
  input  logic [PB_SEL_W-1:0]  p1_sel,
  input  logic [PB_SEL_W-1:0]  p2_sel,
  input  logic [ADC_SEL_W-1:0] adc_sel,
  input  logic [N_HB-1:0]      hb_gate,
  input  logic [N_P1-1:0]      p1_gate,
  input  logic [N_P2-1:0]      p2_gate,
  output logic                 hb_ce,
  output logic                 tick_ce,
  output logic                 p1_ce,
  output logic                 p2_ce,
  output logic                 t1_ce,
  output logic                 t2_ce,
  output logic                 adc_ce,
  output logic [N_HB-1:0]      hb_en,
  output logic [N_P1-1:0]      p1_en,
  output logic [N_P2-1:0]      p2_en
);

  localparam int             TICK_CW     = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [N_HB-1:0] HB_GATE_RST = N_HB'(1) << MEM_IDX;

  logic hb_t, st_t, p1_t, p2_t, t1_t, t2_t, adc_t;

  ckt_div #(.CW(HB_CW)) u_hb_div (
    .clk(clk), .rst(rst), .in_tick(1'b1),
    .div_m1(hb_div_m1(hb_sel)), .tick(hb_t)
  );

  ckt_div #(.CW(TICK_CW)) u_tick_div (
    .clk(clk), .rst(rst), .in_tick(hb_t),
    .div_m1(TICK_CW'(TICK_DIV - 1)), .tick(st_t)
  );

  ckt_bus_pre u_p1_pre (
    .clk(clk), .rst(rst), .in_tick(hb_t), .sel(p1_sel),
    .bus_tick(p1_t), .tim_tick(t1_t)
  );

  ckt_bus_pre u_p2_pre (
    .clk(clk), .rst(rst), .in_tick(hb_t), .sel(p2_sel),
    .bus_tick(p2_t), .tim_tick(t2_t)
  );

  ckt_div #(.CW(ADC_CW)) u_adc_div (
    .clk(clk), .rst(rst), .in_tick(p2_t),
    .div_m1(adc_div_m1(adc_sel)), .tick(adc_t)
  );

  ckt_gate_bank #(.N(N_HB), .RST_VAL(HB_GATE_RST)) u_hb_gates (
    .clk(clk), .rst(rst), .tick(hb_t), .gate_in(hb_gate), .en(hb_en)
  );

  ckt_gate_bank #(.N(N_P1), .RST_VAL('0)) u_p1_gates (
    .clk(clk), .rst(rst), .tick(p1_t), .gate_in(p1_gate), .en(p1_en)
  );

  ckt_gate_bank #(.N(N_P2), .RST_VAL('0)) u_p2_gates (
    .clk(clk), .rst(rst), .tick(p2_t), .gate_in(p2_gate), .en(p2_en)
  );

  // one register stage for every strobe keeps all domains aligned
  always_ff @(posedge clk) begin
    if (rst) begin
      hb_ce   <= 1'b0;
      tick_ce <= 1'b0;
      p1_ce   <= 1'b0;
      p2_ce   <= 1'b0;
      t1_ce   <= 1'b0;
      t2_ce   <= 1'b0;
      adc_ce  <= 1'b0;
    end else begin
      hb_ce   <= hb_t;
      tick_ce <= st_t;
      p1_ce   <= p1_t;
      p2_ce   <= p2_t;
      t1_ce   <= t1_t;
      t2_ce   <= t2_t;
      adc_ce  <= adc_t;
    end
  end

  AST_TICK_ON_HB: assert property (@(posedge clk) disable iff (rst) tick_ce |-> hb_ce)
    else $error("tick strobe off main bus"); // R2
  AST_BUS_ON_HB: assert property (@(posedge clk) disable iff (rst) (p1_ce | p2_ce) |-> hb_ce)
    else $error("bus strobe off main bus"); // R3
  AST_TIM_ON_HB: assert property (@(posedge clk) disable iff (rst) (t1_ce | t2_ce) |-> hb_ce)
    else $error("timer strobe off main bus"); // R10
  AST_ADC_ON_P2: assert property (@(posedge clk) disable iff (rst) adc_ce |-> p2_ce)
    else $error("ADC strobe off bus 2"); // R5

endmodule

// File: tb/test_clk_strobe_tree.sv
module test_clk_strobe_tree;

  localparam int CLK_PERIOD = 10;
  localparam int N_HB = 4;
  localparam int N_P1 = 8;
  localparam int N_P2 = 6;
  localparam int MEM_IDX = 0;
  localparam int TICK_DIV = 8;
  localparam int NS = 7 + N_HB + N_P1 + N_P2;
  localparam int WD_CYCLES = 195000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] cur_h = 4'b1001;
  logic [2:0] cur_p1 = '0, cur_p2 = '0;
  logic [1:0] cur_a = '0;
  logic [N_HB-1:0] cur_ghb = '0;
  logic [N_P1-1:0] cur_g1 = '0;
  logic [N_P2-1:0] cur_g2 = '0;

  logic hb_ce, tick_ce, p1_ce, p2_ce, t1_ce, t2_ce, adc_ce;
  logic [N_HB-1:0] hb_en;
  logic [N_P1-1:0] p1_en;
  logic [N_P2-1:0] p2_en;

  clk_strobe_tree #(.N_HB(N_HB), .N_P1(N_P1), .N_P2(N_P2), .MEM_IDX(MEM_IDX), .TICK_DIV(TICK_DIV)) i_clk_strobe_tree (
    .clk(clk), .rst(rst), .hb_sel(cur_h), .p1_sel(cur_p1), .p2_sel(cur_p2), .adc_sel(cur_a),
    .hb_gate(cur_ghb), .p1_gate(cur_g1), .p2_gate(cur_g2),
    .hb_ce(hb_ce), .tick_ce(tick_ce), .p1_ce(p1_ce), .p2_ce(p2_ce), .t1_ce(t1_ce), .t2_ce(t2_ce),
    .adc_ce(adc_ce), .hb_en(hb_en), .p1_en(p1_en), .p2_en(p2_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;
  bit mon_on = 0;
  int last_t[NS];
  bit seen[NS];
  int nchk[NS];
  int dh_old = 4, dh_new = 4;
  int hb_last = 0;
  bit hb_seen = 0;

  logic [NS-1:0] sv;
  assign sv = {p2_en, p1_en, hb_en, adc_ce, t2_ce, t1_ce, p2_ce, p1_ce, tick_ce, hb_ce};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int dh(input logic [3:0] s);
    if (!s[3]) return 1;
    case (s[2:0])
      3'd0: return 2;   3'd1: return 4;   3'd2: return 8;   3'd3: return 16;
      3'd4: return 64;  3'd5: return 128; 3'd6: return 256; default: return 512;
    endcase
  endfunction

  function automatic int dp(input logic [2:0] s);
    if (!s[2]) return 1;
    case (s[1:0])
      2'd0: return 2; 2'd1: return 4; 2'd2: return 8; default: return 16;
    endcase
  endfunction

  function automatic int da(input logic [1:0] s);
    return 2 * (int'(s) + 1);
  endfunction

  function automatic int slow_of(input logic [3:0] h, input logic [2:0] a1, input logic [2:0] a2, input logic [1:0] ad);
    int m;
    m = TICK_DIV * dh(h);
    if (dh(h) * dp(a1) > m) m = dh(h) * dp(a1);
    if (dh(h) * dp(a2) * da(ad) > m) m = dh(h) * dp(a2) * da(ad);
    return m;
  endfunction

  function automatic int exp_per(input int i);
    int h, b1, b2;
    h = dh(cur_h); b1 = dp(cur_p1); b2 = dp(cur_p2);
    case (i)
      0: return h;
      1: return TICK_DIV * h;
      2: return h * b1;
      3: return h * b2;
      4: return (b1 == 1) ? h : h * b1 / 2;
      5: return (b2 == 1) ? h : h * b2 / 2;
      6: return h * b2 * da(cur_a);
      default: begin
        if (i < 7 + N_HB) return cur_ghb[i-7] ? h : 0;
        if (i < 7 + N_HB + N_P1) return cur_g1[i-7-N_HB] ? h * b1 : 0;
        return cur_g2[i-7-N_HB-N_P1] ? h * b2 : 0;
      end
    endcase
  endfunction

  function automatic string req_of(input int i);
    case (i)
      0: return "R1";
      1: return "R2";
      2, 3: return "R3";
      4, 5: return "R4";
      6: return "R5";
      default: return "R6";
    endcase
  endfunction

  // settled-period monitor for every strobe
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      for (int i = 0; i < NS; i++) begin
        if (sv[i]) begin
          int ep;
          ep = exp_per(i);
          if (ep == 0) chk(0, req_of(i), $sformatf("pulse on closed gate idx %0d", i), 1, 0);
          else begin
            if (seen[i]) begin
              chk(cyc - last_t[i] == ep, req_of(i), $sformatf("period idx %0d", i), cyc - last_t[i], ep);
              nchk[i]++;
            end
            seen[i] = 1;
            last_t[i] = cyc;
          end
        end
      end
      if (sv[NS-1:1] != '0) begin
        // r10_ alignment: derived strobes only on a main-bus strobe
        chk(hb_ce == 1'b1, "R10", "derived strobe without hb_ce", int'(hb_ce), 1);
        if (adc_ce) chk(p2_ce == 1'b1, "R10", "adc_ce without p2_ce", int'(p2_ce), 1);
      end
    end
  end

  // R8: every main-bus interval is the old or the new period
  always @(negedge clk) begin
    if (rst) hb_seen = 0;
    else if (hb_ce) begin
      if (hb_seen)
        chk((cyc - hb_last == dh_old) || (cyc - hb_last == dh_new), "R8", "hb_ce interval across change",
            cyc - hb_last, dh_new);
      hb_seen = 1;
      hb_last = cyc;
    end
  end

  task automatic run_cfg(input logic [3:0] h, input logic [2:0] a1, input logic [2:0] a2, input logic [1:0] ad,
                         input logic [N_HB-1:0] gh, input logic [N_P1-1:0] g1, input logic [N_P2-1:0] g2);
    int s_old, s_new, settle;
    s_old = slow_of(cur_h, cur_p1, cur_p2, cur_a);
    s_new = slow_of(h, a1, a2, ad);
    settle = 3 * ((s_old > s_new) ? s_old : s_new) + 8;
    mon_on = 0;
    @(posedge clk); #1;
    dh_old = dh_new;
    cur_h = h; cur_p1 = a1; cur_p2 = a2; cur_a = ad;
    cur_ghb = gh; cur_g1 = g1; cur_g2 = g2;
    dh_new = dh(h);
    repeat (settle) @(posedge clk);
    #1;
    for (int i = 0; i < NS; i++) begin seen[i] = 0; nchk[i] = 0; end
    mon_on = 1;
    repeat (3 * s_new + 8) @(posedge clk);
    #1;
    mon_on = 0;
    dh_old = dh_new;
    for (int i = 0; i < NS; i++)
      if (exp_per(i) != 0)
        chk(nchk[i] > 0, req_of(i), $sformatf("no measured period idx %0d", i), nchk[i], 1);
  endtask

  task automatic wait_pulse_p1(output bit ok);
    int n;
    n = 0;
    do begin @(negedge clk); n++; end while (!p1_ce && n < 20000);
    ok = p1_ce;
  endtask

  task automatic wait_pulse_hb(output bit ok);
    int n;
    n = 0;
    do begin @(negedge clk); n++; end while (!hb_ce && n < 20000);
    ok = hb_ce;
  endtask

  initial begin
    bit ok;
    void'($urandom(32'd20240611));
    // R9: quiet in reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sv == '0, "R9", "strobes during reset", int'(sv != '0), 0);

    // R7: memory gate open after reset, others closed
    @(posedge clk); #1 rst = 0;
    wait_pulse_hb(ok);
    chk(ok, "R7", "first hb_ce after reset", int'(ok), 1);
    chk(hb_en == N_HB'(1) << MEM_IDX, "R7", "hb_en on first strobe", int'(hb_en), 1 << MEM_IDX);
    chk(p1_en == '0 && p2_en == '0, "R7", "bus gates after reset", int'(p1_en) + int'(p2_en), 0);
    wait_pulse_hb(ok);
    chk(hb_en == '0, "R6", "hb_en after gate sampled closed", int'(hb_en), 0);

    // R6: gate lag of one bus strobe, opening then closing
    cur_p1 = 3'b101;
    repeat (200) @(posedge clk);
    wait_pulse_p1(ok);
    cur_g1[0] = 1'b1;
    wait_pulse_p1(ok);
    chk(p1_en[0] == 1'b0, "R6", "open: strobe that samples gate", int'(p1_en[0]), 0);
    wait_pulse_p1(ok);
    chk(p1_en[0] == 1'b1, "R6", "open: following strobe", int'(p1_en[0]), 1);
    cur_g1[0] = 1'b0;
    wait_pulse_p1(ok);
    chk(p1_en[0] == 1'b1, "R6", "close: strobe that samples gate", int'(p1_en[0]), 1);
    wait_pulse_p1(ok);
    chk(p1_en[0] == 1'b0, "R6", "close: following strobe", int'(p1_en[0]), 0);

    // directed corners: all undivided (timer equals bus), slowest, 16 vs 64 neighbours
    run_cfg(4'b0000, 3'b000, 3'b011, 2'b00, '1, '1, '1);
    run_cfg(4'b0000, 3'b111, 3'b111, 2'b11, 4'b0101, 8'hA5, 6'h2C);
    run_cfg(4'b1111, 3'b000, 3'b000, 2'b00, 4'b1001, 8'h0F, 6'h30);
    run_cfg(4'b1000, 3'b100, 3'b100, 2'b10, 4'b0010, 8'h81, 6'h01);
    run_cfg(4'b1011, 3'b100, 3'b011, 2'b10, '1, 8'h3C, 6'h11);
    run_cfg(4'b1100, 3'b101, 3'b000, 2'b01, 4'b1000, 8'h00, 6'h3F);

    for (int k = 0; k < 12; k++) begin
      logic [3:0] h;
      logic [2:0] a1, a2;
      logic [1:0] ad;
      a1 = 3'($urandom); a2 = 3'($urandom); ad = 2'($urandom);
      h = 4'($urandom);
      for (int t = 0; t < 4 && slow_of(h, a1, a2, ad) > 1024; t++) h = 4'($urandom);
      if (slow_of(h, a1, a2, ad) > 1024) h = 4'b0000;
      run_cfg(h, a1, a2, ad, N_HB'($urandom), N_P1'($urandom), N_P2'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule